// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block is a data cache placed between a processor load/store port and a main-memory port that moves one 32-bit word per beat. It holds 32 KB as four ways of 256 lines, each line eight words long. A 32-bit byte address is split into a line index (bits 12 to 5), a word-in-line select (bits 4 to 2) and a 19-bit tag (bits 31 to 13). Each line keeps its tag, a valid flag and a modified flag.

A miss allocates a line on reads and on writes alike. The controller picks the replacement way, writes the old line back to memory first if that line was modified, and then fetches the whole aligned line. A write miss finishes as a write hit on the freshly loaded line. A mode input chosen with each request selects write-back or write-through handling. Two maintenance commands act on the whole cache: one discards every line, and the other copies every modified line back to memory.

Top module: `dcache_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cpu_ready` is 1, `cpu_rvalid` is 0 and `mem_req` is 0. Whenever `cpu_ready` is 1, `mem_req` is 0.
- R2: The set index is address bits 12 to 5 and the tag is bits 31 to 13. An access whose tag matches a valid line in any of the four ways of its set is a hit and completes without any memory beat.
- R3: A read completes by raising `cpu_rvalid` for exactly one cycle, with the word on `cpu_rdata`, in the same cycle that `cpu_ready` returns to 1. A read hit accepted at one clock edge completes after the second edge.
- R4: A miss fetches all 8 words of the line with memory reads. The reads start at the 32-byte-aligned base address and rise by 4 per beat.
- R5: The replacement way is the lowest-numbered invalid way of the set. If all four ways are valid, it is the way given by a 2-bit counter that starts at 0 after reset and advances by one, wrapping from 3 to 0, on every line allocation.
- R6: If the chosen way holds a valid modified line, its 8 words are written to memory at the address rebuilt from its stored tag and index, starting at word 0, before the fetch begins. Its modified flag is then cleared.
- R7: In write-back mode (`wt_mode`=0) a write hit updates only the cache and marks the line modified. No memory beat occurs.
- R8: In write-through mode (`wt_mode`=1) a write updates the cache and also performs one memory write of that word at its word-aligned address. The line is not marked modified.
- R9: A write miss first fetches the whole line, then applies the write under the mode in effect.
- R10: A clean command writes every valid modified line back to memory and clears its modified flag. After it, memory holds the latest value of every written word, and a second clean causes no memory beat.
- R11: An invalidate command clears the valid and modified flags of every line in one cycle, with no memory beat. The next access to any address is a miss.
- R12: Once `mem_req` is raised, `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold steady until a cycle with `mem_ack`=1. `mem_addr` is always word-aligned.
- R13: Commands are taken only while `cpu_ready`=1. `maint_inv` takes priority over `maint_clean`, which takes priority over `cpu_req`. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wt_mode | input | 1 | Write policy sampled with each request: 1 = write-through, 0 = write-back |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Controller idle, a command is accepted this cycle |
| cpu_rvalid | output | 1 | One-cycle pulse qualifying read data |
| cpu_rdata | output | 32 | Read data |
| maint_inv | input | 1 | Invalidate all lines |
| maint_clean | input | 1 | Write back all modified lines |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current beat |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The properties assume that memory returns `mem_ack` only while `mem_req` is high and that maintenance and access inputs are only meaningful while `cpu_ready` is 1. The bench's memory responder drives `mem_ack` only in answer to a pending request. In one phase it withholds the acknowledge on alternate cycles, so that held beats happen. Stimulus changes on falling edges, and requests are deasserted once the controller has left its idle state.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int NUM_WAYS   = 4;
    localparam int NUM_SETS   = 256;
    localparam int LINE_WORDS = 8;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WORD_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BYTE_W;
    localparam int SCAN_W = WAY_W + IDX_W;
    localparam int LINE_ADDR_W = ADDR_W - BYTE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WAY_W-1:0]  way_t;

    // word address split into its cache fields
    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        word_t word;
    } line_addr_t;

    typedef struct packed {
        logic       we;
        logic       wt;
        line_addr_t loc;
        data_t      wdata;
    } cpu_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WTMEM,
        ST_EVICT,
        ST_FILL,
        ST_INV,
        ST_SCAN
    } dc_state_e;

    function automatic line_addr_t loc_of(input addr_t a);
        return line_addr_t'(a[ADDR_W-1:BYTE_W]);
    endfunction

    function automatic addr_t byte_addr(input tag_t t, input idx_t i, input word_t w);
        return {t, i, w, {BYTE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/dc_way.sv
module dc_way
    import dcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    input  word_t rd_word,
    output logic  rd_valid,
    output logic  rd_dirty,
    output tag_t  rd_tag,
    output data_t rd_data,
    input  logic  data_we,
    input  idx_t  wr_idx,
    input  word_t wr_word,
    input  data_t wr_data,
    input  logic  alloc,
    input  tag_t  alloc_tag,
    input  logic  dirty_set,
    input  logic  dirty_clr,
    input  logic  inv_all
);
    localparam int DEPTH = NUM_SETS * LINE_WORDS;

    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;
    tag_t                tag_q  [NUM_SETS];
    data_t               data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (alloc) begin
                valid_q[wr_idx] <= 1'b1;
                dirty_q[wr_idx] <= 1'b0;
            end
            if (dirty_set) dirty_q[wr_idx] <= 1'b1;
            if (dirty_clr) dirty_q[wr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) tag_q[wr_idx] <= alloc_tag;
    end

    always_ff @(posedge clk) begin
        if (data_we) data_q[{wr_idx, wr_word}] <= wr_data;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[{rd_idx, rd_word}];

endmodule

// File: rtl/dc_hit.sv
module dc_hit
    import dcache_pkg::*;
(
    input  logic [NUM_WAYS-1:0] way_valid,
    input  tag_t                way_tag [NUM_WAYS],
    input  tag_t                req_tag,
    output logic                hit,
    output way_t                hit_way
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) hit_way = way_t'(w);
        end
    end

endmodule

// File: rtl/dc_victim.sv
module dc_victim
    import dcache_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_WAYS-1:0] set_valid,
    input  logic                advance,
    output way_t                victim
);
    way_t ctr_q;

    // power-of-two way count: natural wrap
    always_ff @(posedge clk) begin
        if (rst)          ctr_q <= '0;
        else if (advance) ctr_q <= ctr_q + way_t'(1);
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = ctr_q;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!set_valid[w] && !found) begin
                victim = way_t'(w);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcache_core.sv
module dcache_core
    import dcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              maint_inv,
    input  logic              maint_clean,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam word_t LAST_WORD = word_t'(LINE_WORDS - 1);

    dc_state_e          st_q;
    cpu_req_t           req_q;
    word_t              beat_q;
    way_t               fill_way_q;
    way_t               ev_way_q;
    idx_t               ev_idx_q;
    tag_t               ev_tag_q;
    logic               ev_to_scan_q;
    logic [SCAN_W-1:0]  scan_q;
    logic               rvalid_q;
    data_t              rdata_q;

    idx_t                look_idx;
    word_t               look_word;
    logic [NUM_WAYS-1:0] w_valid;
    logic [NUM_WAYS-1:0] w_dirty;
    tag_t                w_tag  [NUM_WAYS];
    data_t               w_data [NUM_WAYS];

    logic                hit;
    way_t                hit_way;
    way_t                victim;
    logic                last_beat;
    logic                inv_all;
    logic                vic_adv;
    idx_t                wr_idx;
    word_t               wr_word;
    data_t               wr_data;
    logic [NUM_WAYS-1:0] data_we;
    logic [NUM_WAYS-1:0] alloc;
    logic [NUM_WAYS-1:0] dset;
    logic [NUM_WAYS-1:0] dclr;

    way_t scan_way;
    idx_t scan_idx;
    assign scan_way = scan_q[SCAN_W-1:IDX_W];
    assign scan_idx = scan_q[IDX_W-1:0];

    // which line the arrays present this cycle
    always_comb begin
        case (st_q)
            ST_SCAN: begin
                look_idx  = scan_idx;
                look_word = '0;
            end
            ST_EVICT: begin
                look_idx  = ev_idx_q;
                look_word = beat_q;
            end
            default: begin
                look_idx  = req_q.loc.idx;
                look_word = req_q.loc.word;
            end
        endcase
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        dc_way u_way (
            .clk       (clk),
            .rst       (rst),
            .rd_idx    (look_idx),
            .rd_word   (look_word),
            .rd_valid  (w_valid[w]),
            .rd_dirty  (w_dirty[w]),
            .rd_tag    (w_tag[w]),
            .rd_data   (w_data[w]),
            .data_we   (data_we[w]),
            .wr_idx    (wr_idx),
            .wr_word   (wr_word),
            .wr_data   (wr_data),
            .alloc     (alloc[w]),
            .alloc_tag (req_q.loc.tag),
            .dirty_set (dset[w]),
            .dirty_clr (dclr[w]),
            .inv_all   (inv_all)
        );
    end

    dc_hit u_hit (
        .way_valid (w_valid),
        .way_tag   (w_tag),
        .req_tag   (req_q.loc.tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    dc_victim u_victim (
        .clk       (clk),
        .rst       (rst),
        .set_valid (w_valid),
        .advance   (vic_adv),
        .victim    (victim)
    );

    assign last_beat = mem_ack && (beat_q == LAST_WORD);
    assign inv_all   = (st_q == ST_INV);
    assign vic_adv   = (st_q == ST_FILL) && last_beat;
    assign wr_idx    = (st_q == ST_EVICT) ? ev_idx_q : req_q.loc.idx;
    assign wr_word   = (st_q == ST_FILL) ? beat_q : req_q.loc.word;
    assign wr_data   = (st_q == ST_FILL) ? mem_rdata : req_q.wdata;

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            data_we[w] = ((st_q == ST_FILL) && mem_ack && (fill_way_q == way_t'(w)))
                      || ((st_q == ST_LOOK) && hit && req_q.we && (hit_way == way_t'(w)));
            alloc[w]   = (st_q == ST_FILL) && last_beat && (fill_way_q == way_t'(w));
            dset[w]    = (st_q == ST_LOOK) && hit && req_q.we && !req_q.wt
                      && (hit_way == way_t'(w));
            dclr[w]    = (st_q == ST_EVICT) && last_beat && (ev_way_q == way_t'(w));
        end
    end

    // memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q)
            ST_WTMEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr(req_q.loc.tag, req_q.loc.idx, req_q.loc.word);
                mem_wdata = req_q.wdata;
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr(ev_tag_q, ev_idx_q, beat_q);
                mem_wdata = w_data[ev_way_q];
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = byte_addr(req_q.loc.tag, req_q.loc.idx, beat_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            req_q        <= '0;
            beat_q       <= '0;
            fill_way_q   <= '0;
            ev_way_q     <= '0;
            ev_idx_q     <= '0;
            ev_tag_q     <= '0;
            ev_to_scan_q <= 1'b0;
            scan_q       <= '0;
            rvalid_q     <= 1'b0;
            rdata_q      <= '0;
        end else begin
            rvalid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (maint_inv) begin
                        st_q <= ST_INV;
                    end else if (maint_clean) begin
                        scan_q <= '0;
                        st_q   <= ST_SCAN;
                    end else if (cpu_req) begin
                        req_q.we    <= cpu_we;
                        req_q.wt    <= wt_mode;
                        req_q.loc   <= loc_of(cpu_addr);
                        req_q.wdata <= cpu_wdata;
                        st_q        <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit) begin
                        if (!req_q.we) begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= w_data[hit_way];
                            st_q     <= ST_IDLE;
                        end else begin
                            st_q <= req_q.wt ? ST_WTMEM : ST_IDLE;
                        end
                    end else begin
                        fill_way_q <= victim;
                        beat_q     <= '0;
                        if (w_valid[victim] && w_dirty[victim]) begin
                            ev_way_q     <= victim;
                            ev_idx_q     <= req_q.loc.idx;
                            ev_tag_q     <= w_tag[victim];
                            ev_to_scan_q <= 1'b0;
                            st_q         <= ST_EVICT;
                        end else begin
                            st_q <= ST_FILL;
                        end
                    end
                end
                ST_WTMEM: begin
                    if (mem_ack) st_q <= ST_IDLE;
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + word_t'(1);
                        if (beat_q == LAST_WORD) st_q <= ev_to_scan_q ? ST_SCAN : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + word_t'(1);
                        if (beat_q == LAST_WORD) st_q <= ST_LOOK;
                    end
                end
                ST_INV: begin
                    st_q <= ST_IDLE;
                end
                ST_SCAN: begin
                    if (w_valid[scan_way] && w_dirty[scan_way]) begin
                        ev_way_q     <= scan_way;
                        ev_idx_q     <= scan_idx;
                        ev_tag_q     <= w_tag[scan_way];
                        ev_to_scan_q <= 1'b1;
                        beat_q       <= '0;
                        st_q         <= ST_EVICT;
                    end else if (scan_q == '1) begin
                        st_q <= ST_IDLE;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready  = (st_q == ST_IDLE);
    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;

endmodule

// File: rtl/dcache_core_chk.sv
module dcache_core_chk
    import dcache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              maint_inv,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    // R3
    rvalid_at_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> cpu_ready);

    // R3
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |=> !cpu_rvalid);

    // R4
    fill_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && !mem_we) |-> (mem_addr[BYTE_W+WORD_W-1:BYTE_W] == '0));

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && (mem_addr[BYTE_W+WORD_W-1:BYTE_W] != '1))
        |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8))));

    // R11
    inv_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && maint_inv) |=> (!cpu_ready && !mem_req));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

    // R12
    mem_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[BYTE_W-1:0] == '0));

endmodule

bind dcache_core dcache_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .maint_inv  (maint_inv),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/dcache_core_tb_top.sv
`timescale 1ns/1ps
module dcache_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wt_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        maint_inv = 1'b0;
    logic        maint_clean = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    dcache_core dut_i (
        .clk(clk), .rst(rst), .wt_mode(wt_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .maint_inv(maint_inv), .maint_clean(maint_clean),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [31:0] mem_store [int];
    logic [31:0] pview     [int];
    bit          m_valid [4][256];
    bit          m_dirty [4][256];
    int          m_tag   [4][256];
    int          m_vc = 0;

    int          rd_beats = 0;
    int          wr_beats = 0;
    logic [31:0] first_rd_addr = '0;
    logic [31:0] first_wr_addr = '0;
    bit          stall_en  = 1'b0;
    bit          stall_tog = 1'b0;
    bit          held      = 1'b0;
    logic [31:0] held_addr = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input int k);
        if (mem_store.exists(k)) return mem_store[k];
        return (k * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] pv_rd(input int k);
        if (pview.exists(k)) return pview[k];
        return mem_rd(k);
    endfunction

    // memory responder, compared every clock
    always @(negedge clk) begin
        stall_tog = ~stall_tog;
        if (held && mem_req)
            chk(mem_addr == held_addr, "R12", "address held while unacknowledged", mem_addr, held_addr);
        held = 1'b0;
        if (!rst && mem_req && (!stall_en || stall_tog)) begin
            int k;
            k = int'(mem_addr >> 2);
            mem_ack = 1'b1;
            if (mem_we) begin
                if (wr_beats == 0) first_wr_addr = mem_addr;
                wr_beats++;
                chk(mem_wdata == pv_rd(k), "R6", "written word is latest value", mem_wdata, pv_rd(k));
                mem_store[k] = mem_wdata;
            end else begin
                if (rd_beats == 0) first_rd_addr = mem_addr;
                rd_beats++;
                mem_rdata = mem_rd(k);
            end
        end else begin
            mem_ack = 1'b0;
            if (!rst && mem_req) begin
                held      = 1'b1;
                held_addr = mem_addr;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic access(input bit we, input bit wt, input logic [31:0] addr,
                          input logic [31:0] wd, input string rq);
        int k, idx, tg, hw, vic, exp_rd, exp_wr;
        logic [31:0] exp_ev, exp_data;
        bit has_ev;
        k   = int'(addr >> 2);
        idx = int'((addr >> 5) & 32'hFF);
        tg  = int'(addr >> 13);
        hw = -1;
        for (int w = 0; w < 4; w++) if (m_valid[w][idx] && m_tag[w][idx] == tg) hw = w;
        exp_rd = 0; exp_wr = 0; has_ev = 1'b0; exp_ev = '0;
        if (hw < 0) begin
            vic = -1;
            for (int w = 0; w < 4; w++) if (!m_valid[w][idx] && vic < 0) vic = w;
            if (vic < 0) vic = m_vc;
            if (m_valid[vic][idx] && m_dirty[vic][idx]) begin
                exp_wr = 8;
                has_ev = 1'b1;
                exp_ev = (32'(m_tag[vic][idx]) << 13) | (32'(idx) << 5);
            end
            exp_rd = 8;
            m_valid[vic][idx] = 1'b1;
            m_dirty[vic][idx] = 1'b0;
            m_tag[vic][idx]   = tg;
            m_vc = (m_vc + 1) % 4;
            hw = vic;
        end
        if (we) begin
            if (wt) exp_wr += 1;
            else    m_dirty[hw][idx] = 1'b1;
        end
        exp_data = pv_rd(k);
        wait_idle();
        if (we) pview[k] = wd;
        rd_beats = 0; wr_beats = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; wt_mode = wt;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
        chk(rd_beats == exp_rd, rq, "memory read beats", 32'(rd_beats), 32'(exp_rd));
        chk(wr_beats == exp_wr, rq, "memory write beats", 32'(wr_beats), 32'(exp_wr));
        if (exp_rd != 0)
            chk(first_rd_addr == (addr & ~32'h1F), "R4", "fill start address", first_rd_addr, addr & ~32'h1F);
        if (has_ev)
            chk(first_wr_addr == exp_ev, "R6", "eviction start address", first_wr_addr, exp_ev);
        if (!we) begin
            chk(cpu_rvalid == 1'b1, "R3", "read valid pulse", 32'(cpu_rvalid), 32'd1);
            chk(cpu_rdata == exp_data, rq, "read data", cpu_rdata, exp_data);
        end else begin
            chk(cpu_rvalid == 1'b0, "R3", "no valid on write", 32'(cpu_rvalid), 32'd0);
        end
    endtask

    // inv/clean with an optional competing read request (R13)
    task automatic maint(input bit inv, input bit cln, input bit with_req, input string rq);
        int exp_wr, cyc;
        bit saw_rv;
        exp_wr = 0;
        if (inv) begin
            for (int w = 0; w < 4; w++)
                for (int i = 0; i < 256; i++) begin
                    m_valid[w][i] = 1'b0;
                    m_dirty[w][i] = 1'b0;
                end
        end else begin
            for (int w = 0; w < 4; w++)
                for (int i = 0; i < 256; i++)
                    if (m_valid[w][i] && m_dirty[w][i]) begin
                        exp_wr += 8;
                        m_dirty[w][i] = 1'b0;
                    end
        end
        wait_idle();
        rd_beats = 0; wr_beats = 0;
        maint_inv = inv; maint_clean = cln;
        cpu_req = with_req; cpu_we = 1'b0; cpu_addr = 32'h1000_0100;
        @(negedge clk);
        maint_inv = 1'b0; maint_clean = 1'b0; cpu_req = 1'b0;
        cyc = 0; saw_rv = 1'b0;
        while (!cpu_ready) begin
            @(negedge clk);
            cyc++;
            if (cpu_rvalid) saw_rv = 1'b1;
        end
        if (inv) begin
            pview.delete();
            chk(cyc == 1, "R11", "invalidate busy cycles", 32'(cyc), 32'd1);
        end
        chk(wr_beats == exp_wr, rq, "maintenance write beats", 32'(wr_beats), 32'(exp_wr));
        chk(rd_beats == 0, rq, "maintenance read beats", 32'(rd_beats), 32'd0);
        if (with_req)
            chk(saw_rv == 1'b0, "R13", "competing request dropped", 32'(saw_rv), 32'd0);
    endtask

    initial begin
        #(4 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1-timeout: actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(cpu_ready == 1'b1 && mem_req == 1'b0 && cpu_rvalid == 1'b0, "R1", "outputs during reset",
            {29'd0, cpu_ready, mem_req, cpu_rvalid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1 && mem_req == 1'b0 && cpu_rvalid == 1'b0, "R1", "outputs after reset",
            {29'd0, cpu_ready, mem_req, cpu_rvalid}, 32'h4);

        // line 8, way 0, whole-line fill then hit on last word
        access(1'b0, 1'b0, 32'h1000_0100, '0, "R4");
        access(1'b0, 1'b0, 32'h1000_011C, '0, "R2");
        // write-back hit
        access(1'b1, 1'b0, 32'h1000_0104, 32'hDEAD_BEEF, "R7");
        access(1'b0, 1'b0, 32'h1000_0104, '0, "R7");
        // fill remaining ways of set 8, then counter picks dirty way 0
        access(1'b0, 1'b0, 32'h1000_2100, '0, "R5");
        access(1'b0, 1'b0, 32'h1000_4100, '0, "R5");
        access(1'b0, 1'b0, 32'h1000_6100, '0, "R5");
        access(1'b0, 1'b0, 32'h1000_8100, '0, "R6");
        // way 1 replaced next, data comes back from memory
        access(1'b0, 1'b0, 32'h1000_0104, '0, "R5");
        // same tag, other index: separate line
        access(1'b0, 1'b0, 32'h1000_0124, '0, "R2");
        // write-through hit and miss
        access(1'b1, 1'b1, 32'h1000_0108, 32'h1234_5678, "R8");
        access(1'b1, 1'b1, 32'h2000_0444, 32'hCAFE_0001, "R8");
        access(1'b0, 1'b0, 32'h2000_0444, '0, "R9");
        // write-back miss then hit
        access(1'b1, 1'b0, 32'h2000_0040, 32'h0BAD_F00D, "R9");
        access(1'b0, 1'b0, 32'h2000_0040, '0, "R9");
        // clean twice
        maint(1'b0, 1'b1, 1'b0, "R10");
        maint(1'b0, 1'b1, 1'b0, "R10");
        // invalidate, previously cached address misses
        maint(1'b1, 1'b0, 1'b0, "R11");
        access(1'b0, 1'b0, 32'h2000_0040, '0, "R11");
        access(1'b0, 1'b0, 32'h1000_0104, '0, "R11");
        // priority
        access(1'b1, 1'b0, 32'h1000_0110, 32'h5555_AAAA, "R7");
        maint(1'b0, 1'b1, 1'b1, "R13");
        maint(1'b1, 1'b1, 1'b1, "R13");
        access(1'b0, 1'b0, 32'h1000_0110, '0, "R13");

        // mixed traffic with stalled memory
        stall_en = 1'b1;
        for (int n = 0; n < 160; n++) begin
            logic [31:0] a;
            a = {3'd1, 13'(32'($urandom_range(0, 5))), 8'(32'($urandom_range(0, 2)) * 3 + 8),
                 3'(32'($urandom_range(0, 7))), 2'b00};
            access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom, "R5");
        end
        stall_en = 1'b0;
        maint(1'b0, 1'b1, 1'b0, "R10");
        foreach (pview[k])
            chk(mem_rd(k) == pview[k], "R10", "memory holds latest value", mem_rd(k), pview[k]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule